// File: doc/BRIEF.md
# Sequential Register-File Processor Core

This block is a compact, non-pipelined processor core. It fetches one 32-bit instruction at a time from a single word-addressed memory and uses the same port for both program and data. It decodes a fixed-format instruction and executes it against a register file of `NREG` entries, each `XLEN` bits wide. It then updates the program counter. The instruction set covers wrapping arithmetic, signed compare-and-set, absolute conditional and unconditional branches, load and store with base-plus-offset addressing, a call that links to the top register, an indirect jump through a register, and a halt.

The memory is expected to be synchronous with one cycle of read latency. The core presents an address, and the word at that address appears on the read-data input on the following cycle. A write is committed on the clock edge at which the write enable is high. Once the core stops, either on a halt or on an undefined opcode, it raises `halted_o` and stays stopped until reset. A combinational debug port reads any register at any time, so a harness can inspect the result of a program.

Top module: `cpu_core`

## Requirements
- R1: While reset is held and after it is released, `halted_o` and `illegal_o` are low, the program counter is 0 and every register reads 0. Register 0 always reads 0, and any write aimed at it is dropped.
- R2: The instruction word is split into fields as follows: bits [31:26] opcode, [25:21] destination index, [20:16] first source index, and [15:0] a constant that is sign-extended to 32 bits. The opcode values are ADD=0, ADDI=1, SUB=2, SUBI=3, MUL=4, SGE=5, SGT=6, SEQ=7, SEQI=8, BT=9, BF=10, BA=11, LD=12, ST=13, CALL=14, JMP=15 and HALT=16.
- R3: For two-register operations (ADD, SUB, MUL, SGE, SGT, SEQ), the second operand is the register indexed by the constant's low log2(NREG) bits. All other constant bits are ignored for this purpose.
- R4: ADD and SUB work on two registers, and ADDI and SUBI work on the first source and the constant. All four wrap modulo 2^32. MUL keeps the low 32 bits of the product.
- R5: SGE, SGT and SEQ compare the first source with the second operand as signed values, and SEQI compares the first source with the constant. The destination receives 1 when the relation holds and 0 when it does not.
- R6: BT loads the program counter with the constant when the first source is nonzero. BF does so when the first source is zero. BA does so unconditionally. None of the three writes a register, and the program counter takes the low AW bits of the constant.
- R7: LD and ST use the effective address first source + constant. In the third cycle of the instruction, that address appears on `mem_addr_o`. ST raises `mem_we_o` for exactly that one cycle, with the destination-field register on `mem_wdata_o`, and writes no register. LD writes the returned word to the destination. Both take four cycles.
- R8: CALL writes the instruction's own address + 1 into register NREG-1 (r31), whatever the destination field says, and jumps to the constant. JMP loads the program counter with the low AW bits of the first source and writes no register.
- R9: HALT writes nothing. `halted_o` rises in the cycle after the halt's third cycle and stays high, and `mem_addr_o` stays at the halt's own address.
- R10: An opcode above 16 raises `illegal_o` together with `halted_o`, writes nothing, and leaves `mem_addr_o` at the faulting instruction's address.
- R11: Each instruction that is not a load or store takes three cycles. In the first cycle, `mem_addr_o` carries the instruction address, and `mem_we_o` stays low in the first and second cycles. When no jump is taken, the next instruction's address is the current one + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_addr_o | output | AW | Word address for fetch, load and store |
| mem_rdata_i | input | XLEN | Read data, valid one cycle after the address |
| mem_wdata_o | output | XLEN | Store data |
| mem_we_o | output | 1 | Store strobe |
| halted_o | output | 1 | Core stopped |
| illegal_o | output | 1 | Core stopped on an undefined opcode |
| dbg_raddr_i | input | RIW | Debug register index |
| dbg_rdata_o | output | XLEN | Debug register value, combinational |

## Verification
The timing seen at the ports is fixed:
- **Instruction address:** on the port in the first cycle of every instruction.
- **Load/store address and store strobe:** in the third cycle.
- **Register writes (arithmetic, compare, call):** visible on the debug port from the fourth cycle.
- **Load results:** visible from the fifth cycle.
- **`halted_o`:** rises in the cycle after a halt's third cycle.

The bench runs its own instruction-level model, which knows these cycle counts. It steps that model cycle by cycle, sampling one nanosecond after each falling edge, and compares the address, the strobe, the store data and the halt flags in exactly the cycle where each is due. When the program stops, it compares every register through the debug port and the stored word in memory against the model.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam logic [5:0] OP_ADD  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd1;
  localparam logic [5:0] OP_SUB  = 6'd2;
  localparam logic [5:0] OP_SUBI = 6'd3;
  localparam logic [5:0] OP_MUL  = 6'd4;
  localparam logic [5:0] OP_SGE  = 6'd5;
  localparam logic [5:0] OP_SGT  = 6'd6;
  localparam logic [5:0] OP_SEQ  = 6'd7;
  localparam logic [5:0] OP_SEQI = 6'd8;
  localparam logic [5:0] OP_BT   = 6'd9;
  localparam logic [5:0] OP_BF   = 6'd10;
  localparam logic [5:0] OP_BA   = 6'd11;
  localparam logic [5:0] OP_LD   = 6'd12;
  localparam logic [5:0] OP_ST   = 6'd13;
  localparam logic [5:0] OP_CALL = 6'd14;
  localparam logic [5:0] OP_JMP  = 6'd15;
  localparam logic [5:0] OP_HALT = 6'd16;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_HALT
  } state_e;
endpackage

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRP  = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [RIW-1:0]            waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [NRP-1:0][RIW-1:0]   raddr_i,
  output logic [NRP-1:0][XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] rf_q [NREG];

  // entry 0 is reset and never written
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++)
        if (we_i && waddr_i == RIW'(i)) rf_q[i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rd
    assign rdata_o[p] = rf_q[raddr_i[p]];
  end

  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> rf_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_ADDI: res_o = a_i + imm_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_SUBI: res_o = a_i - imm_i;
      OP_MUL:  res_o = a_i * b_i;
      OP_SGE:  res_o = XLEN'($signed(a_i) >= $signed(b_i));
      OP_SGT:  res_o = XLEN'($signed(a_i) >  $signed(b_i));
      OP_SEQ:  res_o = XLEN'(a_i == b_i);
      OP_SEQI: res_o = XLEN'(a_i == imm_i);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int AW   = 10,
  localparam int RIW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  output logic            halted_o,
  output logic            illegal_o,
  input  logic [RIW-1:0]  dbg_raddr_i,
  output logic [XLEN-1:0] dbg_rdata_o
);
  localparam int NRP = 4;
  localparam logic [RIW-1:0] LINK = RIW'(NREG - 1);

  state_e          state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic [31:0]     ir_q;
  logic            ill_q, ill_d;

  logic [5:0]      op;
  logic [RIW-1:0]  rd, rs1, rs2;
  logic [XLEN-1:0] imm, a, b, alu_res;
  logic [AW-1:0]   ea;

  logic                     rf_we;
  logic [RIW-1:0]           rf_waddr;
  logic [XLEN-1:0]          rf_wdata;
  logic [NRP-1:0][RIW-1:0]  rf_ra;
  logic [NRP-1:0][XLEN-1:0] rf_rd;

  assign op  = ir_q[31:26];
  assign rd  = ir_q[21 +: RIW];
  assign rs1 = ir_q[16 +: RIW];
  assign rs2 = ir_q[0 +: RIW];
  assign imm = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

  assign rf_ra = {dbg_raddr_i, rd, rs2, rs1};
  assign a           = rf_rd[0];
  assign b           = rf_rd[1];
  assign mem_wdata_o = rf_rd[2];
  assign dbg_rdata_o = rf_rd[3];
  assign ea          = AW'(a + imm);

  cpu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRP(NRP)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_ra),
    .rdata_o (rf_rd)
  );

  cpu_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (op),
    .a_i   (a),
    .b_i   (b),
    .imm_i (imm),
    .res_o (alu_res)
  );

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    ill_d      = ill_q;
    rf_we      = 1'b0;
    rf_waddr   = rd;
    rf_wdata   = alu_res;
    mem_addr_o = pc_q;
    mem_we_o   = 1'b0;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        state_d = ST_FETCH;
        pc_d    = pc_q + AW'(1);
        unique case (op)
          OP_ADD, OP_ADDI, OP_SUB, OP_SUBI, OP_MUL,
          OP_SGE, OP_SGT, OP_SEQ, OP_SEQI: rf_we = 1'b1;
          OP_BT:  if (a != '0) pc_d = imm[AW-1:0];
          OP_BF:  if (a == '0) pc_d = imm[AW-1:0];
          OP_BA:  pc_d = imm[AW-1:0];
          OP_LD: begin
            mem_addr_o = ea;
            pc_d       = pc_q;
            state_d    = ST_MEM;
          end
          OP_ST: begin
            mem_addr_o = ea;
            mem_we_o   = 1'b1;
            pc_d       = pc_q;
            state_d    = ST_MEM;
          end
          OP_CALL: begin
            rf_we    = 1'b1;
            rf_waddr = LINK;
            rf_wdata = XLEN'(pc_q) + XLEN'(1);
            pc_d     = imm[AW-1:0];
          end
          OP_JMP:  pc_d = a[AW-1:0];
          OP_HALT: begin
            pc_d    = pc_q;
            state_d = ST_HALT;
          end
          default: begin
            pc_d    = pc_q;
            ill_d   = 1'b1;
            state_d = ST_HALT;
          end
        endcase
      end
      ST_MEM: begin
        state_d  = ST_FETCH;
        pc_d     = pc_q + AW'(1);
        rf_we    = (op == OP_LD);
        rf_wdata = mem_rdata_i;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ill_q   <= ill_d;
      if (state_q == ST_DECODE) ir_q <= mem_rdata_i;
    end
  end

  assign halted_o  = (state_q == ST_HALT);
  assign illegal_o = ill_q;

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(mem_addr_o));
  assert_illegal_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);
  assert_store_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_seq_advance_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && op <= OP_SEQI) |=> pc_q == $past(pc_q) + AW'(1));
endmodule

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW   = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_ni = 1'b0;
  logic [AW-1:0]   mem_addr;
  logic [XLEN-1:0] mem_rdata;
  logic [XLEN-1:0] mem_wdata;
  logic            mem_we;
  logic            halted, illegal;
  logic [4:0]      dbg_addr = '0;
  logic [XLEN-1:0] dbg_data;

  cpu_core #(.XLEN(XLEN), .NREG(NREG), .AW(AW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .halted_o    (halted),
    .illegal_o   (illegal),
    .dbg_raddr_i (dbg_addr),
    .dbg_rdata_o (dbg_data)
  );

  logic [31:0]   tb_mem [DEPTH];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;

  always @(posedge clk) begin
    if (ld_en) tb_mem[ld_addr] <= ld_data;
    else if (mem_we) tb_mem[mem_addr] <= mem_wdata;
    mem_rdata <= tb_mem[mem_addr];
  end

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] ref_mem [DEPTH];
  logic [31:0] rr [NREG];
  int rpc;
  bit rhalt, rill;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int rd, input int rs, input int k);
    logic [31:0] w;
    w = {op[5:0], rd[4:0], rs[4:0], k[15:0]};
    return w;
  endfunction

  task automatic put(input int a, input logic [31:0] w);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = w; ref_mem[a] = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic begin_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < NREG; i++) rr[i] = '0;
    rpc = 0; rhalt = 1'b0; rill = 1'b0;
    #1;
    chk("R1 reset halted", {31'b0, halted}, 32'd0);
    chk("R1 reset illegal", {31'b0, illegal}, 32'd0);
    chk("R1 reset pc", 32'(mem_addr), 32'd0);
  endtask

  task automatic step();
    logic [31:0] ins, imm, a, b, wv;
    logic [5:0] op;
    logic [4:0] rd, rs, wr;
    int ea, npc;
    bit ismem, wb;
    ins = ref_mem[rpc];
    op = ins[31:26]; rd = ins[25:21]; rs = ins[20:16];
    imm = {{16{ins[15]}}, ins[15:0]};
    a = rr[rs]; b = rr[ins[4:0]];
    ea = int'((a + imm) & (DEPTH - 1));
    ismem = (op == 12) || (op == 13);
    #1;
    chk("R6/R11 fetch address", 32'(mem_addr), 32'(rpc));
    chk("R11 no strobe in fetch", {31'b0, mem_we}, 32'd0);
    chk("R9 running", {31'b0, halted}, 32'd0);
    @(negedge clk); #1;
    chk("R11 no strobe in decode", {31'b0, mem_we}, 32'd0);
    @(negedge clk); #1;
    chk("R7 strobe in third cycle", {31'b0, mem_we}, {31'b0, op == 13});
    if (ismem) chk("R7 effective address", 32'(mem_addr), 32'(ea));
    if (op == 13) chk("R7 store data", mem_wdata, rr[rd]);
    @(negedge clk);
    if (ismem) begin
      #1 chk("R7 single strobe", {31'b0, mem_we}, 32'd0);
      @(negedge clk);
    end
    npc = rpc + 1; wb = 1'b0; wv = '0; wr = rd;
    case (op)
      0:  begin wv = a + b; wb = 1'b1; end
      1:  begin wv = a + imm; wb = 1'b1; end
      2:  begin wv = a - b; wb = 1'b1; end
      3:  begin wv = a - imm; wb = 1'b1; end
      4:  begin wv = a * b; wb = 1'b1; end
      5:  begin wv = {31'b0, $signed(a) >= $signed(b)}; wb = 1'b1; end
      6:  begin wv = {31'b0, $signed(a) > $signed(b)}; wb = 1'b1; end
      7:  begin wv = {31'b0, a == b}; wb = 1'b1; end
      8:  begin wv = {31'b0, a == imm}; wb = 1'b1; end
      9:  if (a != 0) npc = int'(imm & (DEPTH - 1));
      10: if (a == 0) npc = int'(imm & (DEPTH - 1));
      11: npc = int'(imm & (DEPTH - 1));
      12: begin wv = ref_mem[ea]; wb = 1'b1; end
      13: ref_mem[ea] = rr[rd];
      14: begin wv = 32'(rpc + 1); wr = 5'd31; wb = 1'b1; npc = int'(imm & (DEPTH - 1)); end
      15: npc = int'(a & (DEPTH - 1));
      16: begin rhalt = 1'b1; npc = rpc; end
      default: begin rhalt = 1'b1; rill = 1'b1; npc = rpc; end
    endcase
    if (wb && wr != 0) rr[wr] = wv;
    rpc = npc & (DEPTH - 1);
  endtask

  task automatic run_and_check();
    @(negedge clk);
    rst_ni = 1'b1;
    while (!rhalt) step();
    repeat (3) begin
      #1;
      chk("R9/R10 halted", {31'b0, halted}, 32'd1);
      chk("R10 illegal flag", {31'b0, illegal}, {31'b0, rill});
      chk("R9/R10 address held", 32'(mem_addr), 32'(rpc));
      @(negedge clk);
    end
    for (int i = 0; i < NREG; i++) begin
      dbg_addr = 5'(i);
      #1 chk($sformatf("R1/R2/R3/R4/R5/R8 reg %0d", i), dbg_data, rr[i]);
    end
  endtask

  initial begin
    begin_reset();
    put(0,  enc(1, 1, 0, 5));          // r1 = 5
    put(1,  enc(1, 2, 0, -3));         // r2 = -3
    put(2,  enc(0, 3, 1, 16'h0402));   // R3: index from low bits -> r2
    put(3,  enc(2, 4, 2, 16'hFFE1));   // r4 = r2 - r1
    put(4,  enc(4, 5, 1, 2));          // r5 = r1 * r2
    put(5,  enc(5, 6, 1, 2));          // 1
    put(6,  enc(6, 7, 2, 1));          // 0
    put(7,  enc(7, 8, 1, 1));          // 1
    put(8,  enc(8, 9, 2, -3));         // 1
    put(9,  enc(1, 0, 1, 7));          // R1: write to r0 dropped
    put(10, enc(9, 0, 7, 40));         // BT not taken
    put(11, enc(9, 0, 6, 14));         // BT taken
    put(12, enc(1, 10, 0, 99));
    put(13, enc(16, 0, 0, 0));
    put(14, enc(10, 0, 6, 40));        // BF not taken
    put(15, enc(10, 0, 7, 17));        // BF taken
    put(16, enc(16, 0, 0, 0));
    put(17, enc(13, 5, 1, 100));       // store r5 at 105
    put(18, enc(12, 11, 1, 100));      // load it back
    put(19, enc(1, 12, 0, 32767));
    put(20, enc(4, 13, 12, 12));
    put(21, enc(4, 14, 13, 13));       // R4: product wraps
    put(22, enc(14, 3, 0, 30));        // CALL, dest field ignored
    put(23, enc(11, 0, 0, 26));        // BA
    put(24, enc(16, 0, 0, 0));
    put(25, enc(16, 0, 0, 0));
    put(26, enc(16, 0, 0, 0));
    put(30, enc(1, 16, 31, 0));
    put(31, enc(15, 0, 31, 0));        // JMP via r31
    run_and_check();
    chk("R7 stored word", tb_mem[105], ref_mem[105]);

    begin_reset();
    put(0, enc(1, 1, 0, 1));
    put(1, enc(63, 2, 1, 4));          // R10: undefined opcode
    run_and_check();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected halted");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule